// File: doc/BRIEF.md
# Sequenced Parallel ADC Burst Reader

This block drives a dual simultaneous-sampling 16-bit ADC with a parallel data bus whose on-chip sequencer is enabled. When enabled, it first pulses the converter's active-low reset and then waits for a settling interval. After that it runs rounds back to back. Each round has three parts:

- one conversion-start pulse;
- a wait for the converter's busy line to fall;
- a burst of chip-select/read strobe cycles, one per sequenced result word.

Every word is captured at a fixed delay after read falls. The word goes into its own result slot, and a one-cycle valid pulse reports its slot index. A one-cycle frame-done pulse closes the round.

Every interval is given in nanoseconds and turned into a clock-cycle count from the clock-period parameter. A busy line that never falls is handled by a timeout. The timeout sets a sticky error and retries the conversion. Dropping the enable lets the block finish the word in flight, and then it parks the bus idle.

Top module: `adc_seq_reader`

## Requirements
- R1: While rst_ni is low, adc_rst_no, cs_no and rd_no are 1, convst_o, word_valid_o, frame_done_o and err_o are 0, and every result slot is 0.
- R2: Once enabled from idle, adc_rst_no is low for C_RST_LO cycles. It then stays high for C_SETTLE cycles with the bus idle before the first conversion starts.
- R3: convst_o is high for exactly C_CONV consecutive cycles per round, with cs_no and rd_no high. A new pulse starts only after the last word's quiet interval.
- R4: busy_i passes through two synchronising flops. cs_no falls on the second rising edge counted from the first edge that samples busy_i low (that edge counted as the first). Until then the bus stays idle.
- R5: Each word is one strobe cycle with these phases:
  - cs_no low with rd_no high for C_CS_SU cycles;
  - rd_no low for C_RD_LO cycles;
  - rd_no high with cs_no still low for C_RD_HOLD cycles;
  - cs_no high for C_QUIET cycles.
- R6: adc_data_i is sampled on the C_DSU-th rising edge after rd_no falls. Word k lands in slot k, which is bits [16k+15:16k] of slots_o. In the next cycle word_valid_o is high for one cycle and word_idx_o equals k.
- R7: A round reads exactly N_WORDS words, with slot indices 0 to N_WORDS-1 in ascending order.
- R8: frame_done_o is high for one cycle: the first cycle in which cs_no is high again after the last word of a round.
- R9: If busy_i has not fallen within BUSY_TMO_CYC cycles of the end of the conversion pulse, err_o rises and a new conversion pulse starts at once. err_o stays high until rst_ni is asserted.
- R10: With en_i low, a strobe cycle already under way still completes and its word is stored. After that cs_no and rd_no stay high and no conversion starts. Enabling again restarts from the ADC reset pulse.
- R11: Each interval in cycles is the ceiling of its nanosecond value over CLK_PERIOD_NS, with a floor of one. The read-low time is raised to C_DSU when it would be shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| busy_i | input | 1 | Converter busy, asynchronous |
| adc_data_i | input | DATA_W | Parallel data bus from the converter |
| adc_rst_no | output | 1 | Converter reset, active low |
| convst_o | output | 1 | Conversion start |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| slots_o | output | N_WORDS*DATA_W | Result slots, slot k at bits [DATA_W*k +: DATA_W] |
| word_valid_o | output | 1 | One-cycle pulse per stored word |
| word_idx_o | output | IDX_W | Slot index of the stored word |
| frame_done_o | output | 1 | One-cycle end-of-round pulse |
| err_o | output | 1 | Sticky busy-timeout flag |

## Verification
The bench varies the busy-high width from round to round. This separates a block that really waits on the synchronised falling edge from one that counts a fixed delay. A round in which busy never rises exercises the timeout. It also shows that the error flag survives later good rounds.

The data bus carries a distinct value per word and round, and holds junk outside the read-low window. A wrong sampling edge or a wrong slot therefore shows up as a data mismatch. Dropping the enable in the middle of a word, and enabling again later, separates finishing the strobe from aborting it, and it shows that the reset pulse is reissued.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_LO, ST_RST_WAIT, ST_CONV, ST_BUSY,
    ST_CS_SU, ST_RD_LO, ST_RD_HOLD, ST_QUIET
  } seq_state_e;

  // ceil(t/p), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned p_ns);
    int unsigned c;
    c = (t_ns + p_ns - 1) / p_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/adc_busy_sync.sv
`timescale 1ns/1ps
module adc_busy_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic fall_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], busy_i};
  end

  assign fall_o = (sh_q == 2'b10);
endmodule

// File: rtl/adc_phase_timer.sv
`timescale 1ns/1ps
module adc_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q >= len_i - CNT_W'(1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!done_o)   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/adc_result_bank.sv
`timescale 1ns/1ps
module adc_result_bank #(
  parameter int unsigned N_WORDS = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [DATA_W-1:0]         data_i,
  output logic [N_WORDS*DATA_W-1:0] slots_o,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                slot_q <= '0;
      else if (wr_i && idx_i == IDX_W'(g))        slot_q <= data_i;
    end
    assign slots_o[g*DATA_W +: DATA_W] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= wr_i;
      if (wr_i) idx_o <= idx_i;
    end
  end
endmodule

// File: rtl/adc_seq_reader.sv
`timescale 1ns/1ps
module adc_seq_reader
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned N_WORDS       = 8,
  parameter int unsigned T_RST_LOW_NS  = 1200,
  parameter int unsigned T_SETTLE_NS   = 15000000,
  parameter int unsigned T_CONV_NS     = 50,
  parameter int unsigned T_CS_SU_NS    = 20,
  parameter int unsigned T_RD_LOW_NS   = 30,
  parameter int unsigned T_DATA_SU_NS  = 20,
  parameter int unsigned T_RD_HOLD_NS  = 10,
  parameter int unsigned T_QUIET_NS    = 50,
  parameter int unsigned BUSY_TMO_CYC  = 4096,
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      busy_i,
  input  logic [DATA_W-1:0]         adc_data_i,
  output logic                      adc_rst_no,
  output logic                      convst_o,
  output logic                      cs_no,
  output logic                      rd_no,
  output logic [N_WORDS*DATA_W-1:0] slots_o,
  output logic                      word_valid_o,
  output logic [IDX_W-1:0]          word_idx_o,
  output logic                      frame_done_o,
  output logic                      err_o
);
  localparam int unsigned C_RST_LO = ns_to_cyc(T_RST_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned C_SETTLE = ns_to_cyc(T_SETTLE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_CONV   = ns_to_cyc(T_CONV_NS, CLK_PERIOD_NS);
  localparam int unsigned C_CS_SU  = ns_to_cyc(T_CS_SU_NS, CLK_PERIOD_NS);
  localparam int unsigned C_DSU    = ns_to_cyc(T_DATA_SU_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RDL_R  = ns_to_cyc(T_RD_LOW_NS, CLK_PERIOD_NS);
  localparam int unsigned C_RD_LO  = (C_RDL_R < C_DSU) ? C_DSU : C_RDL_R;
  localparam int unsigned C_RD_HLD = ns_to_cyc(T_RD_HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned C_QUIET  = ns_to_cyc(T_QUIET_NS, CLK_PERIOD_NS);
  localparam int unsigned C_TMO    = (BUSY_TMO_CYC == 0) ? 1 : BUSY_TMO_CYC;
  localparam int unsigned CNT_W    = $clog2(C_RST_LO + C_SETTLE + C_CONV + C_CS_SU + C_RD_LO
                                            + C_RD_HLD + C_QUIET + C_TMO + 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] len, cnt;
  logic             done, fall, cap, tmo, restart;
  logic [IDX_W-1:0] wcnt_q;
  logic             last_word;

  assign last_word = (wcnt_q == IDX_W'(N_WORDS - 1));
  assign restart   = (st_d != st_q);

  always_comb begin
    unique case (st_q)
      ST_RST_LO:   len = CNT_W'(C_RST_LO);
      ST_RST_WAIT: len = CNT_W'(C_SETTLE);
      ST_CONV:     len = CNT_W'(C_CONV);
      ST_BUSY:     len = CNT_W'(C_TMO);
      ST_CS_SU:    len = CNT_W'(C_CS_SU);
      ST_RD_LO:    len = CNT_W'(C_RD_LO);
      ST_RD_HOLD:  len = CNT_W'(C_RD_HLD);
      ST_QUIET:    len = CNT_W'(C_QUIET);
      default:     len = CNT_W'(1);
    endcase
  end

  adc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .len_i(len), .cnt_o(cnt), .done_o(done)
  );

  adc_busy_sync u_sync (.clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .fall_o(fall));

  assign tmo = (st_q == ST_BUSY) && en_i && !fall && done;
  assign cap = (st_q == ST_RD_LO) && (cnt == CNT_W'(C_DSU - 1));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (en_i) st_d = ST_RST_LO;
      ST_RST_LO:   if (!en_i) st_d = ST_IDLE; else if (done) st_d = ST_RST_WAIT;
      ST_RST_WAIT: if (!en_i) st_d = ST_IDLE; else if (done) st_d = ST_CONV;
      ST_CONV:     if (done) st_d = en_i ? ST_BUSY : ST_IDLE;
      ST_BUSY: begin
        if (!en_i)     st_d = ST_IDLE;
        else if (fall) st_d = ST_CS_SU;
        else if (done) st_d = ST_CONV;
      end
      ST_CS_SU:    if (done) st_d = ST_RD_LO;
      ST_RD_LO:    if (done) st_d = ST_RD_HOLD;
      ST_RD_HOLD:  if (done) st_d = en_i ? ST_QUIET : ST_IDLE;
      ST_QUIET: begin
        if (done) begin
          if (!en_i)            st_d = ST_IDLE;
          else if (wcnt_q == 0) st_d = ST_CONV;
          else                  st_d = ST_CS_SU;
        end
      end
      default:     st_d = ST_IDLE;
    endcase
  end

  // pins registered from next state: glitch-free, aligned with st_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      adc_rst_no   <= 1'b1;
      convst_o     <= 1'b0;
      cs_no        <= 1'b1;
      rd_no        <= 1'b1;
      wcnt_q       <= '0;
      frame_done_o <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      st_q         <= st_d;
      adc_rst_no   <= (st_d != ST_RST_LO);
      convst_o     <= (st_d == ST_CONV);
      cs_no        <= !(st_d inside {ST_CS_SU, ST_RD_LO, ST_RD_HOLD});
      rd_no        <= (st_d != ST_RD_LO);
      frame_done_o <= (st_q == ST_RD_HOLD) && done && last_word;
      if (tmo) err_o <= 1'b1;
      if (st_q == ST_IDLE)                  wcnt_q <= '0;
      else if (st_q == ST_RD_HOLD && done)  wcnt_q <= last_word ? '0 : wcnt_q + IDX_W'(1);
    end
  end

  adc_result_bank #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(cap), .idx_i(wcnt_q), .data_i(adc_data_i),
    .slots_o(slots_o), .valid_o(word_valid_o), .idx_o(word_idx_o)
  );
endmodule

// File: rtl/adc_seq_reader_chk.sv
`timescale 1ns/1ps
module adc_seq_reader_chk #(
  parameter int unsigned N_WORDS = 8,
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             adc_rst_no,
  input logic             convst_o,
  input logic             cs_no,
  input logic             rd_no,
  input logic             word_valid_o,
  input logic [IDX_W-1:0] word_idx_o,
  input logic             frame_done_o,
  input logic             err_o
);
  p_rd_in_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !cs_no);

  p_conv_bus_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    convst_o |-> (cs_no && rd_no));

  p_rst_bus_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rst_no |-> (cs_no && !convst_o));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  p_idx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (int'(word_idx_o) < N_WORDS));

  p_frame_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (cs_no && rd_no));

  p_frame_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_conv_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(convst_o) |-> $past(en_i));
endmodule

bind adc_seq_reader adc_seq_reader_chk #(.N_WORDS(N_WORDS)) u_chk (.*);

// File: tb/sim_adc_seq_reader.sv
`timescale 1ns/1ps
module sim_adc_seq_reader;
  localparam int P     = 8;
  localparam int NW    = 5;
  localparam int TMO   = 40;
  localparam int SET_NS = 400;

  function automatic int cyc(input int t);
    int c;
    c = (t + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  // R11: interval cycle counts derived independently
  localparam int C_RST_LO = (1200 + P - 1) / P;
  localparam int C_SETTLE = (SET_NS + P - 1) / P;
  localparam int C_CONV   = (50 + P - 1) / P;
  localparam int C_CSU    = (20 + P - 1) / P;
  localparam int C_DSU    = (20 + P - 1) / P;
  localparam int C_RDL    = ((30 + P - 1) / P < C_DSU) ? C_DSU : (30 + P - 1) / P;
  localparam int C_RDH    = (10 + P - 1) / P;
  localparam int C_QUIET  = (50 + P - 1) / P;

  logic clk_i = 1'b0;
  logic rst_ni, en_i, busy_i;
  logic [15:0] adc_data_i;
  logic adc_rst_no, convst_o, cs_no, rd_no, word_valid_o, frame_done_o, err_o;
  logic [NW*16-1:0] slots_o;
  logic [2:0] word_idx_o;

  always #4 clk_i = ~clk_i;

  adc_seq_reader #(
    .CLK_PERIOD_NS(P), .DATA_W(16), .N_WORDS(NW), .T_SETTLE_NS(SET_NS), .BUSY_TMO_CYC(TMO)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .busy_i(busy_i), .adc_data_i(adc_data_i),
    .adc_rst_no(adc_rst_no), .convst_o(convst_o), .cs_no(cs_no), .rd_no(rd_no),
    .slots_o(slots_o), .word_valid_o(word_valid_o), .word_idx_o(word_idx_o),
    .frame_done_o(frame_done_o), .err_o(err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic exp_err = 1'b0;
  logic [15:0] exp_slot [NW];

  function automatic logic [6:0] pins(input logic r, c, cs, rd, fd, v);
    return {r, c, cs, rd, fd, v, exp_err};
  endfunction

  task automatic step(input string tag, input logic [6:0] e, input int e_idx, input logic [15:0] e_dat);
    logic [6:0] a;
    @(negedge clk_i);
    a = {adc_rst_no, convst_o, cs_no, rd_no, frame_done_o, word_valid_o, err_o};
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s pins {rst,conv,cs,rd,fd,val,err} act=%b exp=%b t=%0t", tag, a, e, $time);
    end
    if (e[1]) begin
      n_chk++;
      if (int'(word_idx_o) != e_idx || slots_o[e_idx*16 +: 16] !== e_dat) begin
        n_fail++;
        $display("FAIL R6 word idx/data act=%0d/%h exp=%0d/%h", word_idx_o,
                 slots_o[e_idx*16 +: 16], e_idx, e_dat);
      end
    end
  endtask

  task automatic idle_steps(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, pins(1, 0, 1, 1, 0, 0), 0, 16'h0);
  endtask

  task automatic reset_seq();
    for (int i = 0; i < C_RST_LO; i++) step("R2", pins(0, 0, 1, 1, 0, 0), 0, 16'h0);
    idle_steps("R2", C_SETTLE);
  endtask

  // R3/R4/R9: conversion pulse then busy wait (or timeout)
  task automatic conv_phase(input bit raise, input int nb);
    for (int i = 0; i < C_CONV; i++) begin
      step("R3", pins(1, 1, 1, 1, 0, 0), 0, 16'h0);
      if (i == 0 && raise) busy_i = 1'b1;
    end
    if (raise) begin
      for (int j = C_CONV; j <= nb + 1; j++) begin
        step("R4", pins(1, 0, 1, 1, 0, 0), 0, 16'h0);
        if (j == nb) busy_i = 1'b0;
      end
    end else begin
      idle_steps("R9", TMO);
      exp_err = 1'b1;
    end
  endtask

  task automatic word(input int k, input int rnd, input bit last, input bit drop);
    logic [15:0] v;
    int tot;
    v = 16'h1000 + 16'(rnd * 256) + 16'(k * 17);
    tot = C_CSU + C_RDL + C_RDH;
    for (int i = 0; i < tot; i++) begin
      bit rdl, val;
      rdl = (i >= C_CSU) && (i < C_CSU + C_RDL);
      val = (i == C_CSU + C_DSU);
      step(val ? "R6" : "R5", pins(1, 0, 0, !rdl, 0, val), k, v);
      if (i == C_CSU) begin
        adc_data_i = v;
        if (drop) en_i = 1'b0;
      end
      if (i == C_CSU + C_RDL) adc_data_i = 16'hDEAD;
    end
    exp_slot[k] = v;
    if (drop) begin
      step("R10", pins(1, 0, 1, 1, last, 0), 0, 16'h0);
      idle_steps("R10", 20);
    end else begin
      for (int q = 0; q < C_QUIET; q++)
        step((q == 0 && last) ? "R8" : "R5", pins(1, 0, 1, 1, q == 0 && last, 0), 0, 16'h0);
    end
  endtask

  // R7: N words in ascending slot order
  task automatic round(input int rnd, input int nb, input int drop_k);
    conv_phase(1'b1, nb);
    for (int k = 0; k < NW; k++) begin
      word(k, rnd, k == NW - 1, k == drop_k);
      if (k == drop_k) break;
    end
  endtask

  task automatic check_slots(input string tag);
    for (int k = 0; k < NW; k++) begin
      n_chk++;
      if (slots_o[k*16 +: 16] !== exp_slot[k]) begin
        n_fail++;
        $display("FAIL %s slot %0d act=%h exp=%h", tag, k, slots_o[k*16 +: 16], exp_slot[k]);
      end
    end
  endtask

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; busy_i = 1'b0; adc_data_i = 16'h0;
    for (int k = 0; k < NW; k++) exp_slot[k] = 16'h0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    step("R1", pins(1, 0, 1, 1, 0, 0), 0, 16'h0);
    check_slots("R1");
    rst_ni = 1'b1;
    idle_steps("R10", 3);
    en_i = 1'b1;
    reset_seq();
    round(0, 20, -1);
    round(1, 12, -1);
    round(2, 30, -1);
    // R9 timeout then retry
    conv_phase(1'b0, 0);
    round(3, 20, -1);
    check_slots("R7");
    // R10 drop enable in word 2
    round(4, 16, 2);
    check_slots("R10");
    en_i = 1'b1;
    reset_seq();
    round(5, 15, -1);
    check_slots("R7");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule